// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

A bus-mapped timer with three 16-bit down-counters. A processor programs it through a byte-wide port with a 2-bit address and separate read and write strobes. Three addresses are data ports, one per counter. The fourth address is a control register shared by all channels. Each control write carries a channel-select field, so it configures only the channel it names. Counting advances on a common clock-enable input, `tick_en`, rather than on every clock.

Channel 0 drives the interrupt line. Channels 1 and 2 each drive a plain output pin. Three counting behaviours are supported:
- a one-shot that expires after a programmed count and then holds;
- a rate generator that gives one low tick per period;
- a square wave.

Reload values are loaded byte-wise. A control-selected access mode decides how each data-port access maps onto the low and high bytes.

Each channel runs a four-state machine:
- **IDLE**: stopped, output high.
- **ARMED**: a reload has been accepted and the count is waiting for the next tick.
- **RUN**: counting.
- **EXPIRED**: the one-shot has finished and is holding.

The transitions are:
- **stop**: any state to IDLE, on a control write to the channel, or on a reload of zero or in a hold mode.
- **arm**: IDLE, RUN or EXPIRED to ARMED, on a nonzero reload.
- **start**: ARMED to RUN, on a tick. The period is copied into the count.
- **wrap**: RUN to RUN, on a tick at count 1 in the rate and square modes.
- **expire**: RUN to EXPIRED, on a tick at count 1 in the one-shot mode.

Top module: `tri_interval_timer`

## Requirements
- R1: Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. Address 3 is the control register. A read of address 3 returns the last control byte written, or 0x00 after reset.
- R2: The control byte layout is as follows. Bits 7:6 select the channel, and the value 3 acts on channel 0. Bits 3:1 set the mode: 000 is the one-shot, x10 is the rate generator, x11 is the square wave, and any other value is a hold mode that ignores reloads and keeps the output high. A control write affects only the selected channel. It stops that channel: its output returns high, and for channel 0 the interrupt drops on the next cycle.
- R3: Bit 0 of the control byte requests decimal counting. `bcd_err` shows bit 0 of the most recent control write, and counting stays binary.
- R4: Bits 5:4 set the access mode. With 01, a data write replaces only bits 7:0 of that counter's reload value. With 10, it replaces only bits 15:8. In both cases the other byte is kept and the counter reloads. With 00, data writes are ignored.
- R5: With access mode 11, the first data-port access (read or write, on any port) after a control write uses the low byte, and every later access uses the high byte. A reload happens only on a high-byte write.
- R6: A data-port read returns the low or high byte of the addressed counter's present count, chosen by the same byte rule as writes. `bus_rdata` is 0 while `bus_rd` is low.
- R7: After a reload, the first `tick_en` copies the period into the count. Outputs change only on a tick or a bus write.
- R8: In rate mode with period N ≥ 2, the output is low after the ticks numbered N, 2N, 3N and so on (the first tick after the reload is tick 1). It is high after every other tick.
- R9: In square mode with period N, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks in each period.
- R10: In one-shot mode, the channel expires on tick N+1 after the reload. Channel 0 then raises `irq_out` and holds it until a control write to channel 0 or a new reload of channel 0. A pin channel drives its pin low from the reload until expiry, then high.
- R11: After reset, every channel is in rate mode with a zero reload. `irq_out` is low, both pins are high and `bcd_err` is low.
- R12: A reload value of zero leaves the channel idle. No output events occur and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| tick_en | input | 1 | Count enable shared by all channels |
| irq_out | output | 1 | Channel 0 one-shot expiry interrupt |
| ch1_out | output | 1 | Channel 1 output pin |
| ch2_out | output | 1 | Channel 2 output pin |
| bcd_err | output | 1 | Unsupported decimal-count request flag |

## Verification
The assertions check the following on every cycle:
- the interrupt rises only on a tick;
- the interrupt holds until a control write or a channel 0 data write;
- a control write that selects channel 0 clears the interrupt;
- `bcd_err` follows bit 0 of each control write;
- the outputs do not move without a tick or a write;
- a read of the control address right after a control write returns that byte.

Only the bench's scenarios can show the rest:
- the exact tick on which each rate, square or one-shot edge falls, swept over a range of periods;
- the byte-retention and low/high phase sequencing;
- the live count readback.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MC_TERM,
        MC_RATE,
        MC_SQUARE,
        MC_HOLD
    } mode_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_EXPIRED
    } ch_state_e;

    typedef enum logic [1:0] {
        AM_NONE = 2'b00,
        AM_LOW  = 2'b01,
        AM_HIGH = 2'b10,
        AM_PAIR = 2'b11
    } access_e;

    // Map the 3-bit mode field onto the behaviours this block implements.
    function automatic mode_class_e classify(input logic [2:0] m);
        if (m == 3'b000)
            return MC_TERM;
        else if (m[1:0] == 2'b10)
            return MC_RATE;
        else if (m[1:0] == 2'b11)
            return MC_SQUARE;
        else
            return MC_HOLD;
    endfunction

endpackage

// File: rtl/tri_timer_bus_regs.sv
module tri_timer_bus_regs
    import tri_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [BYTE_W-1:0]              bus_wdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   count_in,
    output logic [BYTE_W-1:0]              bus_rdata,
    output logic                           bcd_err,
    output logic [NUM_CH-1:0]              ctl_hit,
    output logic [2:0]                     ctl_mode,
    output logic [NUM_CH-1:0]              load_hit,
    output logic [NUM_CH-1:0][CNT_W-1:0]   reload_nx
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic [BYTE_W-1:0]            ctrl_q;
    logic                         bcd_q;
    logic                         hi_phase_q;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_q;

    access_e     am;
    logic        ctrl_wr;
    logic        data_acc;
    logic        byte_ok;
    logic        use_high;
    logic [1:0]  sel_raw;
    logic [1:0]  sel_idx;

    assign am       = access_e'(ctrl_q[5:4]);
    assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
    assign data_acc = (bus_wr || bus_rd) && (bus_addr != CTRL_ADDR);
    assign byte_ok  = (am != AM_NONE);
    assign use_high = (am == AM_HIGH) || ((am == AM_PAIR) && hi_phase_q);
    assign sel_raw  = bus_wdata[7:6];
    assign sel_idx  = (int'(sel_raw) >= NUM_CH) ? 2'd0 : sel_raw;
    assign ctl_mode = bus_wdata[3:1];
    assign bcd_err  = bcd_q;

    // Control register, error flag and shared byte phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            bcd_q      <= 1'b0;
            hi_phase_q <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q     <= bus_wdata;
            bcd_q      <= bus_wdata[0];
            hi_phase_q <= 1'b0;
        end else if (data_acc && (am == AM_PAIR)) begin
            hi_phase_q <= 1'b1;
        end
    end

    // Per-channel reload byte merge and load decode.
    for (genvar i = 0; i < NUM_CH; i++) begin : gen_port
        logic port_wr;
        assign port_wr     = bus_wr && (bus_addr == ADDR_W'(i)) && byte_ok;
        assign ctl_hit[i]  = ctrl_wr && (sel_idx == 2'(i));
        assign load_hit[i] = port_wr && ((am != AM_PAIR) || hi_phase_q);

        always_comb begin
            reload_nx[i] = reload_q[i];
            if (port_wr) begin
                if (use_high)
                    reload_nx[i][CNT_W-1:BYTE_W] = bus_wdata;
                else
                    reload_nx[i][BYTE_W-1:0] = bus_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                reload_q[i] <= '0;
            else
                reload_q[i] <= reload_nx[i];
        end
    end

    // Read mux.
    always_comb begin
        logic [CNT_W-1:0] pick;
        pick = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i))
                pick = count_in[i];
        end
        if (!bus_rd)
            bus_rdata = '0;
        else if (bus_addr == CTRL_ADDR)
            bus_rdata = ctrl_q;
        else if (!byte_ok)
            bus_rdata = '0;
        else if (use_high)
            bus_rdata = pick[CNT_W-1:BYTE_W];
        else
            bus_rdata = pick[BYTE_W-1:0];
    end

endmodule

// File: rtl/tri_timer_channel.sv
module tri_timer_channel
    import tri_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit IS_IRQ = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctl_hit,
    input  logic [2:0]       ctl_mode,
    input  logic             load_hit,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             pin_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_e        state_q, state_d;
    logic [2:0]       mode_q, mode_d;
    logic [CNT_W-1:0] period_q, period_d;
    logic [CNT_W-1:0] count_d;
    mode_class_e      mc;
    logic             wave_lvl;

    assign mc = classify(mode_q);

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        period_d = period_q;
        count_d  = count_q;
        if (ctl_hit) begin
            mode_d  = ctl_mode;
            state_d = ST_IDLE;
            count_d = '0;
        end else if (load_hit) begin
            period_d = reload_val;
            if ((reload_val == '0) || (mc == MC_HOLD))
                state_d = ST_IDLE;
            else
                state_d = ST_ARMED;
        end else if (tick_en) begin
            unique case (state_q)
                ST_IDLE:    ;
                ST_ARMED: begin
                    state_d = ST_RUN;
                    count_d = period_q;
                end
                ST_RUN: begin
                    if (count_q <= ONE) begin
                        if (mc == MC_TERM) begin
                            state_d = ST_EXPIRED;
                            count_d = '0;
                        end else begin
                            count_d = period_q;
                        end
                    end else begin
                        count_d = count_q - ONE;
                    end
                end
                ST_EXPIRED: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= 3'b010;
            period_q <= '0;
            count_q  <= '0;
        end else begin
            state_q  <= state_d;
            mode_q   <= mode_d;
            period_q <= period_d;
            count_q  <= count_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_IDLE:    wave_lvl = 1'b1;
            ST_EXPIRED: wave_lvl = 1'b1;
            ST_ARMED:   wave_lvl = (mc != MC_TERM);
            ST_RUN: begin
                unique case (mc)
                    MC_TERM:   wave_lvl = 1'b0;
                    MC_RATE:   wave_lvl = (count_q != ONE);
                    MC_SQUARE: wave_lvl = (count_q > (period_q >> 1));
                    MC_HOLD:   wave_lvl = 1'b1;
                endcase
            end
        endcase
    end

    if (IS_IRQ) begin : gen_irq_pin
        assign pin_q = (state_q == ST_EXPIRED);
    end else begin : gen_wave_pin
        assign pin_q = wave_lvl;
    end

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tri_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq_out,
    output logic              ch1_out,
    output logic              ch2_out,
    output logic              bcd_err
);

    localparam int NUM_CH = 3;
    localparam int CNT_W  = 2 * BYTE_W;

    logic [NUM_CH-1:0][CNT_W-1:0] count_w;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_w;
    logic [NUM_CH-1:0]            ctl_hit_w;
    logic [NUM_CH-1:0]            load_hit_w;
    logic [NUM_CH-1:0]            pin_w;
    logic [2:0]                   ctl_mode_w;

    tri_timer_bus_regs #(
        .NUM_CH (NUM_CH),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .count_in  (count_w),
        .bus_rdata (bus_rdata),
        .bcd_err   (bcd_err),
        .ctl_hit   (ctl_hit_w),
        .ctl_mode  (ctl_mode_w),
        .load_hit  (load_hit_w),
        .reload_nx (reload_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : gen_ch
        tri_timer_channel #(
            .CNT_W  (CNT_W),
            .IS_IRQ (i == 0)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tick_en),
            .ctl_hit    (ctl_hit_w[i]),
            .ctl_mode   (ctl_mode_w),
            .load_hit   (load_hit_w[i]),
            .reload_val (reload_w[i]),
            .count_q    (count_w[i]),
            .pin_q      (pin_w[i])
        );
    end

    assign irq_out = pin_w[0];
    assign ch1_out = pin_w[1];
    assign ch2_out = pin_w[2];

endmodule

// File: rtl/tri_interval_timer_sva.sv
module tri_interval_timer_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       tick_en,
    input logic       irq_out,
    input logic       ch1_out,
    input logic       ch2_out,
    input logic       bcd_err
);

    logic ctrl_wr;
    logic ch0_sel;
    assign ctrl_wr = bus_wr && (bus_addr == 2'd3);
    assign ch0_sel = (bus_wdata[7:6] == 2'd0) || (bus_wdata[7:6] == 2'd3);

    assert_irq_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(tick_en));

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ctrl_wr && !(bus_wr && bus_addr == 2'd0)) |=> irq_out);

    assert_ctrl_clears_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ch0_sel) |=> !irq_out);

    assert_bcd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (bcd_err == $past(bus_wdata[0])));

    assert_quiet_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !bus_wr) |=> $stable({irq_out, ch1_out, ch2_out}));

    assert_ctrl_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3 && $past(ctrl_wr)) |-> (bus_rdata == $past(bus_wdata)));

    assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

bind tri_interval_timer tri_interval_timer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_en   (tick_en),
    .irq_out   (irq_out),
    .ch1_out   (ch1_out),
    .ch2_out   (ch2_out),
    .bcd_err   (bcd_err)
);

// File: tb/tri_interval_timer_bench.sv
module tri_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       irq_out, ch1_out, ch2_out, bcd_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tri_interval_timer u_tri_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq_out   (irq_out),
        .ch1_out   (ch1_out),
        .ch2_out   (ch2_out),
        .bcd_err   (bcd_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R1: reset state
        chk("R11 irq", irq_out, 0);
        chk("R11 ch1", ch1_out, 1);
        chk("R11 ch2", ch2_out, 1);
        chk("R11 bcd", bcd_err, 0);
        rd(2'd3, v); chk("R1 ctrl reset", v, 0);
        rd(2'd0, v); chk("R4 access none read", v, 0);
        chk("R6 idle rdata", bus_rdata, 0);

        // R8: rate sweep on channel 1
        for (int n = 2; n <= 9; n++) begin
            wr(2'd3, 8'h54);
            wr(2'd1, 8'(n));
            chk("R7 before first tick", ch1_out, 1);
            for (int j = 1; j <= 3 * n; j++) begin
                tick();
                chk("R8 rate", ch1_out, (((j - 1) % n) == n - 1) ? 0 : 1);
            end
        end

        // R9: square sweep on channel 2
        for (int n = 1; n <= 9; n++) begin
            wr(2'd3, 8'h96);
            wr(2'd2, 8'(n));
            for (int j = 1; j <= 2 * n + 1; j++) begin
                tick();
                chk("R9 square", ch2_out, ((n - ((j - 1) % n)) > n / 2) ? 1 : 0);
            end
        end

        // R12: zero reload stays idle
        wr(2'd3, 8'h54);
        wr(2'd1, 8'h00);
        for (int j = 0; j < 10; j++) begin
            tick();
            chk("R12 zero reload", ch1_out, 1);
        end

        // R2: hold mode ignores reloads
        wr(2'd3, 8'h52);
        wr(2'd1, 8'h03);
        for (int j = 0; j < 6; j++) begin
            tick();
            chk("R2 hold mode", ch1_out, 1);
        end

        // R10: one-shot on channel 0
        for (int n = 1; n <= 6; n++) begin
            wr(2'd3, 8'h10);
            wr(2'd0, 8'(n));
            for (int j = 1; j <= n; j++) begin
                tick();
                chk("R10 irq before expiry", irq_out, 0);
            end
            tick();
            chk("R10 irq at expiry", irq_out, 1);
            for (int j = 0; j < 3; j++) begin
                tick();
                chk("R10 irq held", irq_out, 1);
            end
            if (n == 6) begin
                wr(2'd0, 8'(n));
                chk("R10 reload clears irq", irq_out, 0);
            end else begin
                wr(2'd3, 8'h10);
                chk("R2 ctrl clears irq", irq_out, 0);
            end
        end

        // R10: one-shot on a pin channel
        wr(2'd3, 8'h90);
        wr(2'd2, 8'h03);
        chk("R10 pin low after load", ch2_out, 0);
        for (int j = 1; j <= 3; j++) begin
            tick();
            chk("R10 pin counting", ch2_out, 0);
        end
        tick();
        chk("R10 pin expired", ch2_out, 1);

        // R2: select value 3 acts on channel 0
        wr(2'd3, 8'hD0);
        wr(2'd0, 8'h02);
        repeat (3) tick();
        chk("R2 select3 irq", irq_out, 1);
        rd(2'd3, v); chk("R1 ctrl readback", v, 8'hD0);
        wr(2'd3, 8'h14);
        chk("R2 rate clears irq", irq_out, 0);
        wr(2'd0, 8'h02);
        for (int j = 0; j < 6; j++) begin
            tick();
            chk("R11 rate no irq", irq_out, 0);
        end

        // R3: decimal request flag, binary counting kept
        wr(2'd3, 8'h55);
        chk("R3 flag set", bcd_err, 1);
        wr(2'd1, 8'h04);
        for (int j = 1; j <= 8; j++) begin
            tick();
            chk("R3 binary period", ch1_out, (((j - 1) % 4) == 3) ? 0 : 1);
        end
        wr(2'd3, 8'h54);
        chk("R3 flag clear", bcd_err, 0);

        // R5 / R4 / R6: byte sequencing, retention and readback
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h03);
        repeat (3) tick();
        chk("R5 low byte no load", ch1_out, 1);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h54);
        wr(2'd1, 8'h02);
        tick();
        rd(2'd1, v); chk("R6 count low", v, 8'h02);
        wr(2'd3, 8'hA4);
        rd(2'd1, v); chk("R4 high byte kept", v, 8'h01);
        wr(2'd3, 8'h64);
        wr(2'd1, 8'h00);
        tick();
        wr(2'd3, 8'h94);
        rd(2'd1, v); chk("R4 low byte kept", v, 8'h02);
        tick();
        chk("R2 other channel undisturbed", ch1_out, 0);
        wr(2'd3, 8'hB4);
        rd(2'd1, v); chk("R5 first access low", v, 8'h01);
        rd(2'd1, v); chk("R5 second access high", v, 8'h00);
        rd(2'd1, v); chk("R5 later access high", v, 8'h00);
        wr(2'd2, 8'h00);
        for (int j = 1; j <= 6; j++) begin
            tick();
            chk("R5 high write loads", ch2_out, (((j - 1) % 3) == 2) ? 0 : 1);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule